// File: doc/BRIEF.md
# APM Command SMI Trigger with Lockable Feature Negotiation

This block turns byte writes to a power-management command port into system-management interrupt requests for the processors of a multi-CPU system. Two reserved command values do not raise an interrupt. One sets an ACPI-enable state and the other clears it, and each of these writes also produces a one-cycle pulse. Every other command value raises an interrupt, but only while the APM-command enable bit of an interrupt-enable register is set.

Firmware negotiates a feature set with the block. It first writes a requested feature vector. It then fires a features-ok trigger. The block compares the request with a host-supported vector that is fixed by a parameter. A request that is a subset of the host set is copied into a negotiated register, and the ok flag is raised. After that the negotiated set stays fixed until reset. Feature bit 0 selects broadcast delivery. With this bit negotiated, every CPU receives the interrupt. Without it, only the CPU that issued the command write receives it.

A separate lock bit freezes itself and bit 0 of the interrupt-enable register once it is set.

Top module: `apm_smi_ctrl`

## Requirements
- R1: After reset, `smien_q`, `lock_q`, `acpi_en_q`, `req_q`, `fok_q`, `nego_q`, `smi_req`, `acpi_set_p` and `acpi_clr_p` are all zero.
- R2: A command write of value 0xF1 makes `acpi_set_p` high for the one cycle after the write and sets `acpi_en_q` to 1. It raises no interrupt.
- R3: A command write of value 0xF0 makes `acpi_clr_p` high for the one cycle after the write and clears `acpi_en_q`. It raises no interrupt.
- R4: A command write of any value other than 0xF0 or 0xF1 raises an interrupt only when `smien_q` bit 5 (APM-command enable) is 1. Without a command write, `smi_req` is zero.
- R5: When `nego_q` bit 0 is 1, an interrupt sets every bit of `smi_req`. Otherwise it sets only bit `cmd_cpu`.
- R6: A features-ok trigger with a request that has any bit outside `HOST_FEAT` leaves `fok_q` at 0 and `nego_q` at 0.
- R7: A features-ok trigger with a request that is a subset of `HOST_FEAT` sets `fok_q` to 1 and loads `nego_q` with the request, both visible in the cycle after the trigger.
- R8: Once `fok_q` is 1, further triggers are ignored. `fok_q` stays 1 and `nego_q` keeps its value, even if `req_q` changes.
- R9: Reset clears the request register, `fok_q` and `nego_q` after a completed negotiation.
- R10: Once `lock_q` is 1, writes can change neither `lock_q` nor `smien_q` bit 0. The other bits of `smien_q` stay writable.
- R11: Each interrupt request lasts exactly one cycle per command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_data | input | 8 | Command value |
| cmd_cpu | input | CPU_IDX_W | Index of the writing CPU |
| req_wr | input | 1 | Write strobe for the requested feature register |
| req_data | input | FEAT_W | Requested feature value |
| fok_trig | input | 1 | Features-ok trigger |
| smien_wr | input | 1 | Interrupt-enable register write strobe |
| smien_data | input | SMIEN_W | Interrupt-enable write value |
| lock_wr | input | 1 | Lock bit write strobe |
| lock_data | input | 1 | Lock bit write value |
| req_q | output | FEAT_W | Requested feature register |
| fok_q | output | 1 | Features-ok status |
| nego_q | output | FEAT_W | Negotiated feature set |
| smien_q | output | SMIEN_W | Interrupt-enable register |
| lock_q | output | 1 | Lock bit |
| acpi_en_q | output | 1 | ACPI-enable state |
| acpi_set_p | output | 1 | ACPI-enable set pulse |
| acpi_clr_p | output | 1 | ACPI-enable clear pulse |
| smi_req | output | NUM_CPU | Per-CPU interrupt request pulses |

## Verification
The broadcast path is the hardest case to reach. It opens only after a successful negotiation, and that negotiation cannot be undone without a reset. The stimulus therefore sweeps every command value and every CPU index three times. The first pass runs with the enable bit clear. The second runs with the enable bit set and no negotiated features. The third runs after a subset request containing bit 0 has been accepted. Before the third pass, the features-ok rule is covered separately. Each of the sixteen low request patterns is tried after its own reset, and the result is compared with a subset test against the host vector computed in the bench.

// File: rtl/apm_smi_pkg.sv
package apm_smi_pkg;

    localparam logic [7:0] ACPI_ON_CMD  = 8'hF1;
    localparam logic [7:0] ACPI_OFF_CMD = 8'hF0;
    localparam int         APM_EN_BIT   = 5;
    localparam int         GATE_BIT     = 0;
    localparam int         BCAST_BIT    = 0;

    typedef enum logic [1:0] {
        CMD_IDLE     = 2'd0,
        CMD_ACPI_ON  = 2'd1,
        CMD_ACPI_OFF = 2'd2,
        CMD_RAISE    = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        logic set_p;
        logic clr_p;
        logic state;
    } acpi_flags_t;

    function automatic cmd_kind_e classify_cmd(input logic wr, input logic [7:0] v);
        if (!wr)                  return CMD_IDLE;
        else if (v == ACPI_ON_CMD)  return CMD_ACPI_ON;
        else if (v == ACPI_OFF_CMD) return CMD_ACPI_OFF;
        else                      return CMD_RAISE;
    endfunction

endpackage

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode
    import apm_smi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_data,
    input  logic       apm_en,
    output logic       fire,
    output acpi_flags_t acpi
);
    cmd_kind_e kind;
    acpi_flags_t acpi_r;

    always_comb begin
        kind = classify_cmd(cmd_wr, cmd_data);
        fire = (kind == CMD_RAISE) && apm_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acpi_r <= '0;
        end else begin
            acpi_r.set_p <= (kind == CMD_ACPI_ON);
            acpi_r.clr_p <= (kind == CMD_ACPI_OFF);
            if (kind == CMD_ACPI_ON)
                acpi_r.state <= 1'b1;
            else if (kind == CMD_ACPI_OFF)
                acpi_r.state <= 1'b0;
        end
    end

    assign acpi = acpi_r;
endmodule

// File: rtl/feat_negotiator.sv
module feat_negotiator #(
    parameter int                FEAT_W    = 64,
    parameter logic [FEAT_W-1:0] HOST_FEAT = FEAT_W'(5)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_wr,
    input  logic [FEAT_W-1:0] req_data,
    input  logic              fok_trig,
    output logic [FEAT_W-1:0] req_q,
    output logic              fok_q,
    output logic [FEAT_W-1:0] nego_q
);
    logic subset_ok;

    always_comb subset_ok = ((req_q & ~HOST_FEAT) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            fok_q  <= 1'b0;
            nego_q <= '0;
        end else begin
            if (req_wr)
                req_q <= req_data;
            if (fok_trig && !fok_q && subset_ok) begin
                fok_q  <= 1'b1;
                nego_q <= req_q;
            end
        end
    end
endmodule

// File: rtl/smien_lock_regs.sv
module smien_lock_regs
    import apm_smi_pkg::*;
#(
    parameter int SMIEN_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smien_wr,
    input  logic [SMIEN_W-1:0] smien_data,
    input  logic               lock_wr,
    input  logic               lock_data,
    output logic [SMIEN_W-1:0] smien_q,
    output logic               lock_q
);
    logic [SMIEN_W-1:0] wmask;

    always_comb begin
        wmask = '1;
        if (lock_q)
            wmask[GATE_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smien_q <= '0;
            lock_q  <= 1'b0;
        end else begin
            if (smien_wr)
                smien_q <= (smien_q & ~wmask) | (smien_data & wmask);
            if (lock_wr && !lock_q)
                lock_q <= lock_data;
        end
    end
endmodule

// File: rtl/smi_fanout.sv
module smi_fanout #(
    parameter int NUM_CPU   = 4,
    parameter int CPU_IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire,
    input  logic                 bcast,
    input  logic [CPU_IDX_W-1:0] cpu_idx,
    output logic [NUM_CPU-1:0]   smi_req
);
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (rst)
                smi_req[i] <= 1'b0;
            else
                smi_req[i] <= fire && (bcast || (cpu_idx == CPU_IDX_W'(i)));
        end
    end
endmodule

// File: rtl/apm_smi_ctrl.sv
module apm_smi_ctrl
    import apm_smi_pkg::*;
#(
    parameter int                NUM_CPU   = 4,
    parameter int                FEAT_W    = 64,
    parameter int                SMIEN_W   = 32,
    parameter logic [FEAT_W-1:0] HOST_FEAT = FEAT_W'(5),
    localparam int               CPU_IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_wr,
    input  logic [7:0]           cmd_data,
    input  logic [CPU_IDX_W-1:0] cmd_cpu,
    input  logic                 req_wr,
    input  logic [FEAT_W-1:0]    req_data,
    input  logic                 fok_trig,
    input  logic                 smien_wr,
    input  logic [SMIEN_W-1:0]   smien_data,
    input  logic                 lock_wr,
    input  logic                 lock_data,
    output logic [FEAT_W-1:0]    req_q,
    output logic                 fok_q,
    output logic [FEAT_W-1:0]    nego_q,
    output logic [SMIEN_W-1:0]   smien_q,
    output logic                 lock_q,
    output logic                 acpi_en_q,
    output logic                 acpi_set_p,
    output logic                 acpi_clr_p,
    output logic [NUM_CPU-1:0]   smi_req
);
    logic        fire;
    acpi_flags_t acpi;

    apm_cmd_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_data (cmd_data),
        .apm_en   (smien_q[APM_EN_BIT]),
        .fire     (fire),
        .acpi     (acpi)
    );

    feat_negotiator #(.FEAT_W(FEAT_W), .HOST_FEAT(HOST_FEAT)) u_feat (
        .clk      (clk),
        .rst      (rst),
        .req_wr   (req_wr),
        .req_data (req_data),
        .fok_trig (fok_trig),
        .req_q    (req_q),
        .fok_q    (fok_q),
        .nego_q   (nego_q)
    );

    smien_lock_regs #(.SMIEN_W(SMIEN_W)) u_en (
        .clk        (clk),
        .rst        (rst),
        .smien_wr   (smien_wr),
        .smien_data (smien_data),
        .lock_wr    (lock_wr),
        .lock_data  (lock_data),
        .smien_q    (smien_q),
        .lock_q     (lock_q)
    );

    smi_fanout #(.NUM_CPU(NUM_CPU), .CPU_IDX_W(CPU_IDX_W)) u_fan (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .bcast   (nego_q[BCAST_BIT]),
        .cpu_idx (cmd_cpu),
        .smi_req (smi_req)
    );

    assign acpi_en_q  = acpi.state;
    assign acpi_set_p = acpi.set_p;
    assign acpi_clr_p = acpi.clr_p;
endmodule

// File: rtl/apm_smi_ctrl_chk.sv
module apm_smi_ctrl_chk #(
    parameter int                NUM_CPU   = 4,
    parameter int                FEAT_W    = 64,
    parameter int                SMIEN_W   = 32,
    parameter logic [FEAT_W-1:0] HOST_FEAT = FEAT_W'(5)
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_wr,
    input logic [7:0]         cmd_data,
    input logic               fok_q,
    input logic [FEAT_W-1:0]  nego_q,
    input logic [SMIEN_W-1:0] smien_q,
    input logic               lock_q,
    input logic               acpi_en_q,
    input logic               acpi_set_p,
    input logic [NUM_CPU-1:0] smi_req
);
    p_acpi_on_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_data == 8'hF1) |=> (acpi_set_p && acpi_en_q && smi_req == '0));

    p_acpi_off_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_data == 8'hF0) |=> (!acpi_en_q && smi_req == '0));

    p_no_write_no_smi_r4: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> (smi_req == '0));

    p_disabled_no_smi_r4: assert property (@(posedge clk) disable iff (rst)
        !smien_q[5] |=> (smi_req == '0));

    p_target_shape_r5: assert property (@(posedge clk) disable iff (rst)
        (smi_req != '0) |-> (smi_req == '1 || $countones(smi_req) == 1));

    p_nego_subset_r6: assert property (@(posedge clk) disable iff (rst)
        fok_q |-> ((nego_q & ~HOST_FEAT) == '0));

    p_fok_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        fok_q |=> (fok_q && $stable(nego_q)));

    p_no_fok_no_nego_r6: assert property (@(posedge clk) disable iff (rst)
        !fok_q |-> (nego_q == '0));

    p_lock_hold_r10: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> (lock_q && $stable(smien_q[0])));
endmodule

bind apm_smi_ctrl apm_smi_ctrl_chk #(
    .NUM_CPU(NUM_CPU), .FEAT_W(FEAT_W), .SMIEN_W(SMIEN_W), .HOST_FEAT(HOST_FEAT)
) u_chk (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .fok_q(fok_q), .nego_q(nego_q), .smien_q(smien_q), .lock_q(lock_q),
    .acpi_en_q(acpi_en_q), .acpi_set_p(acpi_set_p), .smi_req(smi_req)
);

// File: tb/apm_smi_ctrl_tb.sv
module apm_smi_ctrl_tb;
    localparam int          NCPU = 4;
    localparam int          FW   = 64;
    localparam int          SW   = 32;
    localparam logic [FW-1:0] HOST = 64'h5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_wr = 0;
    logic [7:0] cmd_data = 0;
    logic [1:0] cmd_cpu = 0;
    logic req_wr = 0;
    logic [FW-1:0] req_data = 0;
    logic fok_trig = 0;
    logic smien_wr = 0;
    logic [SW-1:0] smien_data = 0;
    logic lock_wr = 0;
    logic lock_data = 0;
    logic [FW-1:0] req_q, nego_q;
    logic fok_q, lock_q, acpi_en_q, acpi_set_p, acpi_clr_p;
    logic [SW-1:0] smien_q;
    logic [NCPU-1:0] smi_req;

    int n_vec = 0;
    int n_bad = 0;
    logic acpi_model = 1'b0;

    always #10 clk = ~clk;

    apm_smi_ctrl #(.NUM_CPU(NCPU), .FEAT_W(FW), .SMIEN_W(SW), .HOST_FEAT(HOST)) u_dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .cmd_cpu(cmd_cpu),
        .req_wr(req_wr), .req_data(req_data), .fok_trig(fok_trig),
        .smien_wr(smien_wr), .smien_data(smien_data), .lock_wr(lock_wr), .lock_data(lock_data),
        .req_q(req_q), .fok_q(fok_q), .nego_q(nego_q), .smien_q(smien_q), .lock_q(lock_q),
        .acpi_en_q(acpi_en_q), .acpi_set_p(acpi_set_p), .acpi_clr_p(acpi_clr_p), .smi_req(smi_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        acpi_model = 1'b0;
    endtask

    task automatic w_smien(input logic [SW-1:0] v);
        @(negedge clk); smien_wr = 1; smien_data = v;
        @(negedge clk); smien_wr = 0;
    endtask

    task automatic w_lock(input logic v);
        @(negedge clk); lock_wr = 1; lock_data = v;
        @(negedge clk); lock_wr = 0;
    endtask

    task automatic w_req(input logic [FW-1:0] v);
        @(negedge clk); req_wr = 1; req_data = v;
        @(negedge clk); req_wr = 0;
    endtask

    task automatic trig();
        @(negedge clk); fok_trig = 1;
        @(negedge clk); fok_trig = 0;
    endtask

    // one command write; checks outputs in the cycle after and the cycle after that
    task automatic cmd(input logic [7:0] v, input logic [1:0] cpu, input logic en, input logic bc);
        logic [NCPU-1:0] exp_smi;
        logic raise;
        @(negedge clk); cmd_wr = 1; cmd_data = v; cmd_cpu = cpu;
        @(negedge clk); cmd_wr = 0;
        raise = (v != 8'hF0) && (v != 8'hF1) && en;
        exp_smi = raise ? (bc ? '1 : NCPU'(1) << cpu) : '0;
        if (v == 8'hF1) acpi_model = 1'b1;
        if (v == 8'hF0) acpi_model = 1'b0;
        chk(bc ? "R5 smi_req bcast" : "R4 smi_req", 64'(smi_req), 64'(exp_smi));
        chk("R2 acpi_set_p", 64'(acpi_set_p), 64'(v == 8'hF1));
        chk("R3 acpi_clr_p", 64'(acpi_clr_p), 64'(v == 8'hF0));
        chk("R2 R3 acpi_en_q", 64'(acpi_en_q), 64'(acpi_model));
        @(negedge clk);
        chk("R11 smi pulse end", 64'(smi_req), 64'(0));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1
        chk("R1 smien_q", 64'(smien_q), 0);
        chk("R1 lock_q", 64'(lock_q), 0);
        chk("R1 acpi_en_q", 64'(acpi_en_q), 0);
        chk("R1 req_q", req_q, 0);
        chk("R1 fok_q", 64'(fok_q), 0);
        chk("R1 nego_q", nego_q, 0);
        chk("R1 smi_req", 64'(smi_req), 0);
        chk("R1 pulses", 64'({acpi_set_p, acpi_clr_p}), 0);

        // R4 disabled sweep
        for (int c = 0; c < 256; c++)
            for (int p = 0; p < NCPU; p++)
                cmd(8'(c), 2'(p), 1'b0, 1'b0);
        // R4 enabled, unicast
        w_smien(32'h20);
        for (int c = 0; c < 256; c++)
            for (int p = 0; p < NCPU; p++)
                cmd(8'(c), 2'(p), 1'b1, 1'b0);
        // R2/R3 ordering: on, on, off, off
        cmd(8'hF1, 0, 1, 0); cmd(8'hF1, 1, 1, 0); cmd(8'hF0, 2, 1, 0); cmd(8'hF0, 3, 1, 0);

        // R6/R7 sweep of request patterns
        for (int r = 0; r < 16; r++) begin
            logic ok;
            do_reset();
            ok = ((64'(r) & ~HOST) == 0);
            w_req(64'(r));
            trig();
            chk(ok ? "R7 fok_q" : "R6 fok_q", 64'(fok_q), 64'(ok));
            chk(ok ? "R7 nego_q" : "R6 nego_q", nego_q, ok ? 64'(r) : 0);
        end

        // R8: invalid then valid then ignored
        do_reset();
        w_req(64'h2); trig();
        chk("R6 fok after bad", 64'(fok_q), 0);
        w_req(64'h1); trig();
        chk("R7 fok after good", 64'(fok_q), 1);
        chk("R7 nego", nego_q, 64'h1);
        w_req(64'h4); trig();
        chk("R8 nego kept", nego_q, 64'h1);
        chk("R8 fok kept", 64'(fok_q), 1);
        chk("R8 req changed", req_q, 64'h4);

        // R5 broadcast sweep
        w_smien(32'h20);
        for (int c = 0; c < 256; c++)
            for (int p = 0; p < NCPU; p++)
                cmd(8'(c), 2'(p), 1'b1, 1'b1);

        // R9
        do_reset();
        chk("R9 req_q", req_q, 0);
        chk("R9 fok_q", 64'(fok_q), 0);
        chk("R9 nego_q", nego_q, 0);
        cmd(8'h42, 2'd2, 1'b0, 1'b0);

        // R10 lock
        w_smien(32'h1);
        w_smien(32'h0);
        chk("R10 bit0 writable before lock", 64'(smien_q), 0);
        w_smien(32'h1);
        w_lock(1'b1);
        chk("R10 lock set", 64'(lock_q), 1);
        w_smien(32'h20);
        chk("R10 bit0 held", 64'(smien_q), 64'h21);
        w_smien(32'hA0);
        chk("R10 other bits writable", 64'(smien_q), 64'hA1);
        w_lock(1'b0);
        chk("R10 lock sticky", 64'(lock_q), 1);
        do_reset();
        chk("R10 R1 lock cleared", 64'(lock_q), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule